// File: doc/BRIEF.md
# Raster Frame Store Write Packer

This block takes decoded picture samples, one 8-bit sample per transfer and in raster order, and packs them into 64-bit memory words. It hands each word on together with the word address it belongs to in an external frame store. The first word of a picture goes to a programmable frame start address. Each following word goes to the next word address. Picture lines follow one another with no padding, so a whole frame occupies one unbroken run of addresses.

Two storage formats are supported. In the luma format every word carries eight consecutive luma samples. In the chroma format the incoming stream alternates red-difference and blue-difference samples (Cr first). These are packed into the same byte lanes, so a chroma line needs as many words as a luma line of the same width. Because chroma is subsampled vertically, only half as many lines are stored. Picture width, picture height, start address and format are loaded through a configuration port while the block is idle. A start pulse runs one frame, and a done flag reports that the last word has been taken downstream. Both the sample input and the word output use valid/ready handshakes.

Top module: `frame_store_packer`

## Requirements
- R1: After reset, busy, done, out_valid and in_ready are all 0.
- R2: Within an output word, the first sample of its group of eight sits in out_data[7:0], the second in [15:8], and so on up to the eighth in [63:56].
- R3: The first word of a frame carries out_addr equal to the configured start address, and each later word of the frame carries the previous word's address plus one.
- R4: A frame emits exactly (width/8) × rows words, with no gap in addresses where one line ends and the next begins.
- R5: With cfg_chroma=1, the number of stored rows is floor(height/2) and the words per line are width/8, the same as in luma. Incoming samples fill the byte lanes in arrival order, so Cr lands in even lanes (bits 7:0, 23:16, ...) and Cb lands in odd lanes.
- R6: The three low bits of the configured width are ignored: the words per line are floor(width/8).
- R7: A configuration write (cfg_we=1) takes effect only when the block is idle and no start is accepted in the same cycle. A write made while busy is discarded and does not affect the current frame or any later one.
- R8: While out_valid=1 and out_ready=0, out_valid, out_addr and out_data hold steady. No completed word is overwritten and no accepted sample is lost.
- R9: done and busy change together, one cycle after the handshake of the last word: done rises and busy falls. done stays high until the next accepted start. A start pulse while busy is ignored.
- R10: A start with a configuration that yields zero words raises done in the next cycle, leaves busy low and emits no word.
- R11: While the block is idle, or after every sample of the frame has been taken, in_ready is 0 and input samples are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chroma | input | 1 | Storage format: 0 luma, 1 interleaved chroma |
| cfg_width | input | WIDTH_W (12) | Picture width in pixels |
| cfg_height | input | HEIGHT_W (12) | Picture height in luma lines |
| cfg_base | input | ADDR_W (24) | Word address of the first word of the frame |
| start | input | 1 | Pulse that begins one frame when idle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | The last frame completed |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted this cycle when in_valid is high |
| in_sample | input | SAMPLE_W (8) | Sample value |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_addr | output | ADDR_W (24) | Word address of out_data |
| out_data | output | SAMPLE_W*LANES (64) | Packed word |

## Verification
The bench builds the block with its default parameters: eight 8-bit lanes, 12-bit width and height fields, and a 24-bit address. Small pictures (32×4, 37×3 and degenerate sizes) therefore exercise every lane, every line seam and the zero-word corner in a few hundred cycles. A start address near 0x3FFC carries the running address across a wide power-of-two boundary. Pseudo-random back-pressure on out_ready exercises the stall that completes a word while the previous one is still waiting.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   // run phase of the packer
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;

   // shift that turns a pixel count into a word count
   function automatic int unsigned lane_shift(input int unsigned lanes);
      return $clog2(lanes);
   endfunction

endpackage

// File: rtl/fsp_cfg_hold.sv
module fsp_cfg_hold #(
   parameter int WIDTH_W  = 12,
   parameter int HEIGHT_W = 12,
   parameter int ADDR_W   = 24,
   parameter int LANE_SH  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock,
   input  logic                cfg_we,
   input  logic                cfg_chroma,
   input  logic [WIDTH_W-1:0]  cfg_width,
   input  logic [HEIGHT_W-1:0] cfg_height,
   input  logic [ADDR_W-1:0]   cfg_base,
   output logic [WIDTH_W-1:0]  words_per_line,
   output logic [HEIGHT_W-1:0] rows,
   output logic [ADDR_W-1:0]   base
);

   logic [WIDTH_W-1:0]  wpl_next;
   logic [HEIGHT_W-1:0] rows_next;

   // derived geometry is computed once at load so the start path stays short
   always_comb begin
      wpl_next  = cfg_width >> LANE_SH;
      rows_next = cfg_chroma ? (cfg_height >> 1) : cfg_height;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words_per_line <= '0;
         rows           <= '0;
         base           <= '0;
      end else if (cfg_we && !lock) begin
         words_per_line <= wpl_next;
         rows           <= rows_next;
         base           <= cfg_base;
      end
   end

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && cfg_we) |=> ($stable(words_per_line) && $stable(rows) && $stable(base))); // R7

endmodule

// File: rtl/fsp_lane_pack.sv
module fsp_lane_pack #(
   parameter int SAMPLE_W = 8,
   parameter int LANES    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        arm,
   input  logic                        take,
   input  logic [SAMPLE_W-1:0]         sample,
   input  logic                        out_ready,
   output logic                        lane_last,
   output logic                        word_push,
   output logic                        out_valid,
   output logic [SAMPLE_W*LANES-1:0]   out_data
);

   localparam int WORD_W  = SAMPLE_W * LANES;
   localparam int LANE_IW = $clog2(LANES);

   logic [LANE_IW-1:0] lane_q;
   logic [WORD_W-1:0]  word_next;

   assign lane_last = (lane_q == LANE_IW'(LANES - 1));
   assign word_push = take && lane_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q <= '0;
      end else if (arm) begin
         lane_q <= '0;
      end else if (take) begin
         lane_q <= lane_q + LANE_IW'(1);
      end
   end

   // one holding register per lower lane; the top lane is fed straight through
   for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
      logic [SAMPLE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (take && lane_q == LANE_IW'(g)) begin
            q <= sample;
         end
      end
      assign word_next[g*SAMPLE_W +: SAMPLE_W] = q;
   end
   assign word_next[(LANES-1)*SAMPLE_W +: SAMPLE_W] = sample;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (word_push) begin
         out_valid <= 1'b1;
         out_data  <= word_next;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      word_push |-> (!out_valid || out_ready)); // R8

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

endmodule

// File: rtl/fsp_addr_seq.sv
module fsp_addr_seq
   import fsp_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int WPL_W  = 12,
   parameter int ROWS_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WPL_W-1:0]  words_per_line,
   input  logic [ROWS_W-1:0] rows,
   input  logic [ADDR_W-1:0] base,
   input  logic              word_push,
   input  logic              out_fire,
   output logic              arm,
   output logic              busy,
   output logic              done,
   output logic              all_issued,
   output logic [ADDR_W-1:0] out_addr
);

   localparam int CNT_W = WPL_W + ROWS_W;

   phase_t            phase_q;
   logic [CNT_W-1:0]  total_q;
   logic [CNT_W-1:0]  issue_q;
   logic [CNT_W-1:0]  ack_q;
   logic [CNT_W-1:0]  total_next;

   assign total_next = CNT_W'(words_per_line) * CNT_W'(rows);
   assign busy       = (phase_q == PH_RUN);
   assign arm        = start && !busy;
   assign all_issued = (issue_q == total_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         done     <= 1'b0;
         total_q  <= '0;
         issue_q  <= '0;
         ack_q    <= '0;
         out_addr <= '0;
      end else if (arm) begin
         total_q <= total_next;
         issue_q <= '0;
         ack_q   <= '0;
         if (total_next == '0) begin
            done <= 1'b1;
         end else begin
            phase_q <= PH_RUN;
            done    <= 1'b0;
         end
      end else if (busy) begin
         if (word_push) begin
            out_addr <= base + ADDR_W'(issue_q);
            issue_q  <= issue_q + CNT_W'(1);
         end
         if (out_fire) begin
            ack_q <= ack_q + CNT_W'(1);
            if (ack_q == total_q - CNT_W'(1)) begin
               phase_q <= PH_IDLE;
               done    <= 1'b1;
            end
         end
      end
   end

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (word_push && issue_q != '0) |=> (out_addr == $past(out_addr) + ADDR_W'(1))); // R3

   AST_ISSUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (issue_q <= total_q && ack_q <= issue_q)); // R4

endmodule

// File: rtl/frame_store_packer.sv
module frame_store_packer
   import fsp_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int LANES    = 8,
   parameter int WIDTH_W  = 12,
   parameter int HEIGHT_W = 12,
   parameter int ADDR_W   = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       cfg_chroma,
   input  logic [WIDTH_W-1:0]         cfg_width,
   input  logic [HEIGHT_W-1:0]        cfg_height,
   input  logic [ADDR_W-1:0]          cfg_base,
   input  logic                       start,
   output logic                       busy,
   output logic                       done,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [SAMPLE_W-1:0]        in_sample,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [ADDR_W-1:0]          out_addr,
   output logic [SAMPLE_W*LANES-1:0]  out_data
);

   localparam int LANE_SH = lane_shift(LANES);

   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_sample
      $error("SAMPLE_W must be positive");
   end
   if (WIDTH_W <= LANE_SH) begin : g_bad_width
      $error("WIDTH_W too small for the lane count");
   end
   if (HEIGHT_W < 1 || ADDR_W < 1) begin : g_bad_geom
      $error("HEIGHT_W and ADDR_W must be positive");
   end

   logic [WIDTH_W-1:0]  words_per_line;
   logic [HEIGHT_W-1:0] rows;
   logic [ADDR_W-1:0]   base;
   logic                arm;
   logic                all_issued;
   logic                lane_last;
   logic                word_push;
   logic                take;
   logic                out_fire;

   assign in_ready = busy && !all_issued && (!lane_last || !out_valid || out_ready);
   assign take     = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;

   fsp_cfg_hold #(
      .WIDTH_W (WIDTH_W),
      .HEIGHT_W(HEIGHT_W),
      .ADDR_W  (ADDR_W),
      .LANE_SH (LANE_SH)
   ) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .lock          (busy || arm),
      .cfg_we        (cfg_we),
      .cfg_chroma    (cfg_chroma),
      .cfg_width     (cfg_width),
      .cfg_height    (cfg_height),
      .cfg_base      (cfg_base),
      .words_per_line(words_per_line),
      .rows          (rows),
      .base          (base)
   );

   fsp_lane_pack #(
      .SAMPLE_W(SAMPLE_W),
      .LANES   (LANES)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .take     (take),
      .sample   (in_sample),
      .out_ready(out_ready),
      .lane_last(lane_last),
      .word_push(word_push),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   fsp_addr_seq #(
      .ADDR_W(ADDR_W),
      .WPL_W (WIDTH_W),
      .ROWS_W(HEIGHT_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .words_per_line(words_per_line),
      .rows          (rows),
      .base          (base),
      .word_push     (word_push),
      .out_fire      (out_fire),
      .arm           (arm),
      .busy          (busy),
      .done          (done),
      .all_issued    (all_issued),
      .out_addr      (out_addr)
   );

   AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_ready); // R11

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(out_addr)); // R8

endmodule

// File: tb/tb_frame_store_packer.sv
module tb_frame_store_packer;

   localparam int AW = 24;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0, cfg_chroma = 1'b0;
   logic [11:0]    cfg_width = '0, cfg_height = '0;
   logic [AW-1:0]  cfg_base = '0;
   logic           start = 1'b0;
   logic           busy, done;
   logic           in_valid = 1'b0, in_ready;
   logic [7:0]     in_sample = '0;
   logic           out_valid, out_ready = 1'b1;
   logic [AW-1:0]  out_addr;
   logic [63:0]    out_data;

   frame_store_packer dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chroma(cfg_chroma),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_base(cfg_base),
      .start(start), .busy(busy), .done(done),
      .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_data(out_data)
   );

   int n_chk = 0, n_bad = 0;
   logic [AW-1:0] q_addr[$];
   logic [63:0]   q_data[$];
   string cur_tag = "R2";
   int n_rx = 0, cyc = 0, fire_cyc = -1, rise_cyc = -1;
   logic done_prev = 1'b0;
   int stall_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // cycle counter, done-edge capture and downstream back-pressure
   always @(negedge clk) begin
      if (done && !done_prev) rise_cyc = cyc;
      done_prev = done;
      cyc++;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= (stall_mode == 0) ? 1'b1 : lfsr[0];
   end

   // scoreboard monitor
   logic hold_v = 1'b0;
   logic [AW-1:0] hold_a;
   logic [63:0] hold_d;
   always @(posedge clk) begin
      if (rst_n) begin
         if (hold_v)
            chk(out_valid && out_addr == hold_a && out_data == hold_d,
                "R8 stalled word changed", out_data, hold_d);
         hold_v = out_valid && !out_ready;
         hold_a = out_addr;
         hold_d = out_data;
         if (out_valid && out_ready) begin
            n_rx++;
            fire_cyc = cyc;
            if (q_addr.size() == 0) begin
               chk(1'b0, "R4 unexpected word", 64'(out_addr), 64'(0));
            end else begin
               logic [AW-1:0] ea;
               logic [63:0] ed;
               ea = q_addr.pop_front();
               ed = q_data.pop_front();
               chk(out_addr == ea, "R3 word address", 64'(out_addr), 64'(ea));
               chk(out_data == ed, cur_tag, out_data, ed);
            end
         end
      end
   end

   function automatic logic [7:0] smp(input int seed, input int i, input bit chroma);
      if (chroma)
         return (i % 2 == 0) ? 8'(8'h80 + seed + i / 2) : 8'(8'h20 + seed * 3 + i / 2);
      return 8'(seed * 17 + i * 5 + 1);
   endfunction

   task automatic set_cfg(input bit c, input int w, input int h, input int b);
      @(negedge clk);
      cfg_we = 1'b1; cfg_chroma = c; cfg_width = 12'(w); cfg_height = 12'(h); cfg_base = AW'(b);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_frame(input bit chroma, input int w, input int h, input int b,
                            input int seed, input bit poke, input string tag);
      int wpl, rows, nw, ns, rx0, t;
      logic [63:0] d;
      wpl  = w / 8;
      rows = chroma ? h / 2 : h;
      nw   = wpl * rows;
      ns   = nw * 8;
      cur_tag = tag;
      d = '0;
      for (int i = 0; i < ns; i++) begin
         d[(i % 8) * 8 +: 8] = smp(seed, i, chroma);
         if (i % 8 == 7) begin
            q_addr.push_back(AW'(b + i / 8));
            q_data.push_back(d);
         end
      end
      rx0 = n_rx;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < ns; i++) begin
         in_valid  = 1'b1;
         in_sample = smp(seed, i, chroma);
         if (poke && i == 10) begin
            cfg_we = 1'b1; cfg_chroma = ~chroma; cfg_width = 12'd64;
            cfg_height = 12'd8; cfg_base = AW'(24'h900);
         end
         start = poke && i == 12;
         #1;
         while (!in_ready) begin
            @(negedge clk); cfg_we = 1'b0; start = 1'b0; #1;
         end
         @(negedge clk);
         cfg_we = 1'b0; start = 1'b0;
      end
      in_valid = 1'b0;
      t = 0;
      while (!done && t < 4000) begin
         @(negedge clk); t++;
      end
      #2;
      chk(done && !busy, "R9 done/busy at end", {62'b0, done, busy}, 64'h2);
      chk(rise_cyc == fire_cyc, "R9 done one cycle after last word", 64'(rise_cyc), 64'(fire_cyc));
      chk(n_rx - rx0 == nw, "R4 word count", 64'(n_rx - rx0), 64'(nw));
      chk(q_addr.size() == 0, "R4 words missing", 64'(q_addr.size()), 64'(0));
      #1;
      chk(!in_ready, "R11 in_ready low after frame", 64'(in_ready), 64'(0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(!busy && !done && !out_valid && !in_ready, "R1 reset outputs",
          {60'b0, busy, done, out_valid, in_ready}, 64'h0);

      // R11 idle input not consumed
      in_valid = 1'b1; in_sample = 8'hEE;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk(!in_ready, "R11 in_ready while idle", 64'(in_ready), 64'(0));
      end
      in_valid = 1'b0;

      // R10 zero-word frame from a clean done=0 state
      set_cfg(1'b0, 7, 4, 24'h50);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0; #1;
      chk(done && !busy, "R10 zero frame done next cycle", {62'b0, done, busy}, 64'h2);
      repeat (4) @(negedge clk);
      chk(n_rx == 0, "R10 no words emitted", 64'(n_rx), 64'(0));

      // R2/R3/R4 luma, free-flowing output
      set_cfg(1'b0, 32, 4, 24'h100);
      run_frame(1'b0, 32, 4, 24'h100, 1, 1'b0, "R2 luma lane order");

      // R8 same geometry under back-pressure
      stall_mode = 1;
      run_frame(1'b0, 32, 4, 24'h100, 2, 1'b0, "R8 luma under stall");

      // R7 + R9: config write and start pulse while busy are ignored
      run_frame(1'b0, 32, 4, 24'h100, 3, 1'b1, "R7 busy config ignored");
      run_frame(1'b0, 32, 4, 24'h100, 4, 1'b0, "R7 old config still in force");

      // R5 chroma: interleaved Cr/Cb, half the rows, idle write takes effect
      set_cfg(1'b1, 32, 4, 24'h2000);
      run_frame(1'b1, 32, 4, 24'h2000, 5, 1'b0, "R5 chroma interleave");
      stall_mode = 0;
      set_cfg(1'b1, 16, 5, 24'h30);
      run_frame(1'b1, 16, 5, 24'h30, 6, 1'b0, "R5 chroma odd height");

      // R6 width low bits ignored, address crossing a wide boundary
      stall_mode = 1;
      set_cfg(1'b0, 37, 3, 24'h3FFC);
      run_frame(1'b0, 37, 3, 24'h3FFC, 7, 1'b0, "R6 width truncation");

      // R10 chroma with a single line yields zero rows
      set_cfg(1'b1, 32, 1, 24'h10);
      begin
         int rx0;
         rx0 = n_rx;
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0; #1;
         chk(done && !busy, "R10 chroma one-line frame", {62'b0, done, busy}, 64'h2);
         repeat (4) @(negedge clk);
         chk(n_rx == rx0, "R10 no words for zero rows", 64'(n_rx - rx0), 64'(0));
      end

      summary();
      $finish;
   end

endmodule